// File: doc/BRIEF.md
# Table-Driven Register Datapath Sequencer

This block is a small arithmetic engine. It has a few 32-bit working registers, one decrement unit, one multiplier and a constant-one source. A writable control table steers it instead of fixed states. Each table row names, for one clock step, which registers load and from which source. It also gives the register operands of the decrement and multiply units, a register whose zero status chooses the following row, two candidate next rows, and a halt mark. With one program the hardware computes N*(N-1). With a different program loaded through the same write port, it loops to compute N!.

Software or a host first fills the table through the write port. A one-cycle start pulse then copies the input N into the count register and points the row pointer at row 0. From the next clock edge, one row runs per cycle. Every enabled register loads in parallel, so independent updates such as decrementing the count while multiplying the accumulator share a cycle. When the running row carries the halt mark, the done flag goes high. The result output then holds steady until the next start.

Top module: `ucode_dp_seq`

## Requirements
- R1: After synchronous active-low reset, done is 0 and result is 0.
- R2: At the clock edge that samples start high, register 0 (the count register) takes the value of n_in and the row pointer returns to row 0; the first row runs at the following edge.
- R3: A register changes only at an edge where the executing row sets its load-enable bit. A halt row loads nothing, and while idle no register changes, so a program consisting only of a halt row leaves result at its prior value.
- R4: The multiplier source is the low 32 bits of the product of its two operand registers, and the decrement source is its operand register minus 1 modulo 2^32.
- R5: After a non-halt row, the row pointer moves to the alternate-next field when the register chosen by the zero-test field is zero, otherwise to the next field; the test uses register values from before that row's loads.
- R6: At the edge that executes a halt row, done goes to 1. Afterwards, until the next start, done stays 1 and result stays constant.
- R7: A start pulse clears done at its edge and restarts the program at row 0 even if a run is in progress.
- R8: Several registers enabled in one row all load at that same edge, each from its own selected source.
- R9: Table row w is written at a clock edge with tbl_we high. The word layout, from bit 0 up, is: next row [3:0], alternate next row [7:4], halt [8], load enables [11:9] (bit 9+i for register i), source selects [17:12] (two bits per register, register i at bits 12+2i; 0 = n_in, 1 = decrement result, 2 = product, 3 = constant 1), decrement operand [19:18], multiplier operands [21:20] and [23:22], zero-test register [25:24]. Operand index 3 reads as zero.
- R10: With the factorial program, N = 0 yields 1.
- R11: Result is register 1. Done rises exactly k edges after the start edge, where k is the number of rows executed including the halt row: 3 for the two-step product program and 2N+3 for the looping factorial program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse: load N, restart at row 0 |
| n_in | input | 32 | Operand N, sampled with start |
| tbl_we | input | 1 | Control table write enable |
| tbl_addr | input | 4 | Row index to write |
| tbl_wdata | input | 26 | Control word to write |
| done | output | 1 | High once a halt row has run |
| result | output | 32 | Contents of register 1 |

## Verification
The product program runs with a mid-range N, with N = 0 and N = 1, and with an N large enough to wrap the 32-bit product. These cases separate a correct decrement-then-multiply from an off-by-one or truncated datapath. The factorial program runs with N = 0, 1, 5 and 13. The N = 0 case shows the zero test is taken before any multiply. The larger values confirm that the loop count and the two loads in one row line up. N = 13 also checks wrap-around. A two-way branch program run with zero and nonzero N shows which next field is picked. A halt-only program, a hold period after done, and a start issued mid-run show that the result is not disturbed and that a run can be restarted.

// File: rtl/useq_pkg.sv
// Package: shared sizes, source codes and the control word layout.
// Assumes NREG <= 2**SELW - 1 so the top operand index can mean "zero".
package useq_pkg;
    parameter int DW   = 32;
    parameter int NREG = 3;
    parameter int ROWS = 16;

    localparam int PCW     = $clog2(ROWS);
    localparam int SELW    = $clog2(NREG + 1);
    localparam int CNT_IDX = 0;
    localparam int RES_IDX = 1;

    typedef enum logic [1:0] {
        SRC_N   = 2'd0,
        SRC_DEC = 2'd1,
        SRC_MUL = 2'd2,
        SRC_ONE = 2'd3
    } src_e;

    // Packed MSB first: the last field sits at bit 0.
    typedef struct packed {
        logic [SELW-1:0]       zsel;
        logic [SELW-1:0]       mulb;
        logic [SELW-1:0]       mula;
        logic [SELW-1:0]       decsel;
        logic [NREG-1:0][1:0]  src;
        logic [NREG-1:0]       ld;
        logic                  halt;
        logic [PCW-1:0]        alt;
        logic [PCW-1:0]        nxt;
    } uword_t;

    localparam int UW = $bits(uword_t);
endpackage

// File: rtl/useq_ctrl_store.sv
// Control table: ROWS words, one write port, one combinational read port.
// Assumes the row pointer is always below ROWS (guaranteed by PCW sizing).
module useq_ctrl_store
    import useq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [PCW-1:0] waddr,
    input  logic [UW-1:0]  wdata,
    input  logic [PCW-1:0] raddr,
    output uword_t         rword
);
    logic [UW-1:0] mem [ROWS];

    // Table storage: cleared on reset, written one row per enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Row fetch for the step currently executing.
    always_comb begin
        rword = uword_t'(mem[raddr]);
    end
endmodule

// File: rtl/useq_datapath.sv
// Register file with per-register load enable and source select, one
// decrement unit, one multiplier (low DW bits) and a zero test.
// Assumes exec is never high in the same cycle as load_n.
module useq_datapath
    import useq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_n,
    input  logic [DW-1:0] n_in,
    input  logic          exec,
    input  uword_t        uw,
    output logic          zero,
    output logic [DW-1:0] count_q,
    output logic [DW-1:0] result
);
    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] dec_op, mul_a, mul_b, z_op;
    logic [DW-1:0] dec_res, mul_res;
    logic [2*DW-1:0] prod_full;

    // Operand read: index beyond the file returns zero.
    function automatic logic [DW-1:0] rd(input logic [SELW-1:0] idx,
                                          input logic [DW-1:0] r [NREG]);
        logic [DW-1:0] v;
        v = '0;
        for (int k = 0; k < NREG; k++) begin
            if (idx == SELW'(k)) v = r[k];
        end
        return v;
    endfunction

    // Operand muxes for the functional units and the zero test.
    always_comb begin
        dec_op = rd(uw.decsel, regs);
        mul_a  = rd(uw.mula, regs);
        mul_b  = rd(uw.mulb, regs);
        z_op   = rd(uw.zsel, regs);
    end

    // Functional units: decrement and truncated multiply.
    always_comb begin
        dec_res   = dec_op - DW'(1);
        prod_full = mul_a * mul_b;
        mul_res   = prod_full[DW-1:0];
    end

    // Zero status seen by the sequencer.
    always_comb begin
        zero = (z_op == '0);
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] nxt_val;

        // Source select for this register.
        always_comb begin
            unique case (src_e'(uw.src[g]))
                SRC_N:   nxt_val = n_in;
                SRC_DEC: nxt_val = dec_res;
                SRC_MUL: nxt_val = mul_res;
                default: nxt_val = DW'(1);
            endcase
        end

        // Register update: start load for the count register, else row enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (load_n && (g == CNT_IDX)) begin
                regs[g] <= n_in;
            end else if (exec && uw.ld[g]) begin
                regs[g] <= nxt_val;
            end
        end
    end

    // Outputs of fixed registers.
    always_comb begin
        count_q = regs[CNT_IDX];
        result  = regs[RES_IDX];
    end
endmodule

// File: rtl/useq_sequencer.sv
// Row pointer and run state. One row per cycle while running; halt ends
// the run and raises done. Start has priority over everything else.
module useq_sequencer
    import useq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           zero,
    input  uword_t         uw,
    output logic [PCW-1:0] pc,
    output logic           running,
    output logic           exec,
    output logic           done
);
    // A row applies its loads only when it is live and not a halt.
    always_comb begin
        exec = running && !uw.halt && !start;
    end

    // Row pointer, run flag and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else if (start) begin
            pc      <= '0;
            running <= 1'b1;
            done    <= 1'b0;
        end else if (running) begin
            if (uw.halt) begin
                running <= 1'b0;
                done    <= 1'b1;
            end else begin
                pc <= zero ? uw.alt : uw.nxt;
            end
        end
    end
endmodule

// File: rtl/ucode_dp_seq.sv
// Top: table-driven register datapath sequencer. Joins the control table,
// the sequencer and the datapath. Assumes the table is written while idle.
module ucode_dp_seq
    import useq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DW-1:0]          n_in,
    input  logic                   tbl_we,
    input  logic [PCW-1:0]         tbl_addr,
    input  logic [UW-1:0]          tbl_wdata,
    output logic                   done,
    output logic [DW-1:0]          result
);
    uword_t         uw;
    logic [PCW-1:0] pc;
    logic           running;
    logic           exec;
    logic           zero;
    logic [DW-1:0]  count_q;

    useq_ctrl_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .raddr (pc),
        .rword (uw)
    );

    useq_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .zero    (zero),
        .uw      (uw),
        .pc      (pc),
        .running (running),
        .exec    (exec),
        .done    (done)
    );

    useq_datapath u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_n  (start),
        .n_in    (n_in),
        .exec    (exec),
        .uw      (uw),
        .zero    (zero),
        .count_q (count_q),
        .result  (result)
    );
endmodule

// File: rtl/useq_chk.sv
// Checker for ucode_dp_seq, attached by bind below.
module useq_chk
    import useq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [DW-1:0]  n_in,
    input  logic           done,
    input  logic [DW-1:0]  result,
    input  logic           running,
    input  logic [PCW-1:0] pc,
    input  logic           halt,
    input  logic           zero,
    input  logic [PCW-1:0] nxt,
    input  logic [PCW-1:0] alt,
    input  logic [DW-1:0]  count_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && result == '0));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (pc == '0 && count_q == $past(n_in)));

    // R3
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> $stable(result));

    // R5
    branch_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !halt && !start) |=> (pc == ($past(zero) ? $past(alt) : $past(nxt))));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result)));

    // R6
    halt_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && halt && !start) |=> (done && !running));

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && running));
endmodule

bind ucode_dp_seq useq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .n_in    (n_in),
    .done    (done),
    .result  (result),
    .running (running),
    .pc      (pc),
    .halt    (uw.halt),
    .zero    (zero),
    .nxt     (uw.nxt),
    .alt     (uw.alt),
    .count_q (count_q)
);

// File: tb/ucode_dp_seq_test.sv
module ucode_dp_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] n_in = '0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [25:0] tbl_wdata = '0;
    logic        done;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ucode_dp_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .done(done), .result(result)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    // Packs a control word by the bit positions of R9.
    function automatic logic [25:0] mkw(input int nxt, input int alt, input bit halt,
                                        input logic [2:0] ld, input int s0, input int s1,
                                        input int s2, input int dsel, input int ma,
                                        input int mb, input int zs);
        logic [25:0] w;
        w = '0;
        w[3:0]   = 4'(nxt);
        w[7:4]   = 4'(alt);
        w[8]     = halt;
        w[11:9]  = ld;
        w[13:12] = 2'(s0);
        w[15:14] = 2'(s1);
        w[17:16] = 2'(s2);
        w[19:18] = 2'(dsel);
        w[21:20] = 2'(ma);
        w[23:22] = 2'(mb);
        w[25:24] = 2'(zs);
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d (0x%08h) expected=%0d (0x%08h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [25:0] w);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 4'(addr); tbl_wdata = w;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Pulses start, returns edges until done and the result.
    task automatic run(input logic [31:0] n, output int lat);
        @(negedge clk);
        n_in = n; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 1000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic load_prod();   // R9: program for N*(N-1)
        wr(0, mkw(1, 1, 0, 3'b010, 0, 1, 0, 0, 0, 0, 3));
        wr(1, mkw(2, 2, 0, 3'b010, 0, 2, 0, 0, 0, 1, 3));
        wr(2, mkw(0, 0, 1, 3'b000, 0, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic load_fact();   // R9: looping factorial program
        wr(0, mkw(1, 1, 0, 3'b010, 0, 3, 0, 0, 0, 0, 3));
        wr(1, mkw(2, 3, 0, 3'b000, 0, 0, 0, 0, 0, 0, 0));
        wr(2, mkw(1, 1, 0, 3'b011, 1, 2, 0, 0, 1, 0, 3));
        wr(3, mkw(0, 0, 1, 3'b000, 0, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 32'(done), 0);
        chk("R1 result after reset", result, 0);
    endtask

    task automatic t_prod();
        int lat;
        logic [31:0] n, e;
        load_prod();
        n = 7; run(n, lat);
        chk("R2 N*(N-1) N=7", result, 42);
        chk("R11 latency product", lat, 3);
        chk("R6 done after halt", 32'(done), 1);
        n = 0; run(n, lat);
        e = n * (n - 1);
        chk("R4 N*(N-1) N=0 wrap", result, e);
        n = 1; run(n, lat);
        chk("R2 N*(N-1) N=1", result, 0);
        n = 70000; run(n, lat);
        e = n * (n - 1);
        chk("R4 N*(N-1) N=70000 truncated", result, e);
    endtask

    task automatic t_fact();
        int lat;
        logic [31:0] e;
        load_fact();
        run(0, lat);
        chk("R10 factorial N=0", result, 1);
        chk("R11 latency factorial N=0", lat, 3);
        run(1, lat);
        chk("R5 factorial N=1", result, 1);
        run(5, lat);
        chk("R8 factorial N=5", result, 120);
        chk("R11 latency factorial N=5", lat, 13);
        run(13, lat);
        e = 1;
        for (int i = 2; i <= 13; i++) e = e * 32'(i);
        chk("R4 factorial N=13 wrap", result, e);
    endtask

    task automatic t_hold();
        logic [31:0] r;
        r = result;
        repeat (10) @(negedge clk);
        chk("R6 done held", 32'(done), 1);
        chk("R6 result held", result, r);
    endtask

    task automatic t_noload();
        int lat;
        logic [31:0] r;
        r = result;
        wr(0, mkw(0, 0, 1, 3'b111, 1, 1, 1, 0, 0, 0, 0));
        run(99, lat);
        chk("R3 halt row loads nothing", result, r);
        chk("R11 latency halt-only", lat, 1);
    endtask

    task automatic t_branch();
        int lat;
        wr(0, mkw(1, 2, 0, 3'b000, 0, 0, 0, 0, 0, 0, 0));
        wr(1, mkw(3, 3, 0, 3'b010, 0, 3, 0, 0, 0, 0, 3));
        wr(2, mkw(3, 3, 0, 3'b010, 0, 1, 0, 0, 0, 0, 3));
        wr(3, mkw(0, 0, 1, 3'b000, 0, 0, 0, 0, 0, 0, 0));
        run(0, lat);
        chk("R5 zero takes alternate", result, 32'hFFFF_FFFF);
        run(4, lat);
        chk("R5 nonzero takes next", result, 1);
        chk("R11 latency branch", lat, 3);
    endtask

    task automatic t_restart();
        int lat;
        load_fact();
        @(negedge clk);
        n_in = 10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        run(3, lat);
        chk("R7 restart result", result, 6);
        chk("R7 restart latency", lat, 9);
    endtask

    initial begin
        t_reset();
        t_prod();
        t_hold();
        t_fact();
        t_noload();
        t_branch();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule